// File: doc/BRIEF.md
# Command Header Burst Expander

This block turns a command list, carried as a stream of 32-bit words, into single register writes. A list opens with a header word. Depending on the header's mode, zero or more argument words follow it. Each write that leaves the block carries three things: a 13-bit method number, a 3-bit subchannel and a 32-bit value. The mode sets how the method number moves from one argument to the next. It can step on every argument, stay fixed, or step once and then stay. There is also an inline form, whose one write takes its value from the header itself.

A list is armed by pulsing `list_start` together with its length in words. The words then arrive on a valid/ready input, and the writes leave on a valid/ready output. The block keeps a count of every word it consumes, headers and arguments alike. Once that count reaches the list length, it stops accepting words. Three sticky flags record bad lists:
- a reserved mode code,
- a step-once header that has no arguments,
- a list that ends inside a burst.

Top module: `cbe_burst_expander`

## Requirements
- R1: The header fields sit at fixed positions: method in bits 12:0, subchannel in bits 15:13, count or immediate in bits 28:16, mode in bits 31:29. Every write carries the subchannel of the header it came from.
- R2: Mode codes 2 and 0 step the method on every argument. Argument i is written to method+i, modulo 2^13.
- R3: Mode codes 3 and 1 hold the method. Every argument is written to the header method.
- R4: Mode code 5 steps once. Argument 0 goes to the header method, and every later argument goes to method+1, modulo 2^13.
- R5: Mode code 4 is inline. It consumes only the header and issues one write to the header method. The value of that write is header bits 28:16, zero-extended to 32 bits.
- R6: A header in a burst mode with count 0 issues no writes. When that mode is code 5, `err_zero_once` is set and stays set until reset.
- R7: Mode codes 6 and 7 issue no writes. They set `err_unsupported`, which stays set until reset. The next word is then taken as a header.
- R8: `list_start` with a nonzero `list_len` arms a list of that many words. Once that many words have been consumed, `busy` falls and `in_ready` stays low, so extra words are neither taken nor written.
- R9: A list that ends before a burst has all of its arguments cuts the burst short. The writes already issued stand, and `err_truncated` is set and stays set until reset.
- R10: While a write is held (`out_valid` high, `out_ready` low), no input word is consumed. The held write's method, subchannel and value stay stable until it is taken.
- R11: After reset, `out_valid`, `in_ready`, `busy` and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| list_start | input | 1 | Arms a new list when idle |
| list_len | input | LEN_W | Number of words in the list |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word (header or argument) |
| in_ready | output | 1 | Block accepts the input word |
| out_valid | output | 1 | A write is presented |
| out_method | output | 13 | Method number of the write |
| out_subch | output | 3 | Subchannel of the write |
| out_value | output | 32 | Value of the write |
| out_ready | input | 1 | Consumer takes the write |
| busy | output | 1 | A list is being processed |
| err_unsupported | output | 1 | Sticky: reserved mode seen |
| err_zero_once | output | 1 | Sticky: step-once header with count 0 |
| err_truncated | output | 1 | Sticky: list ended inside a burst |

## Verification
The checker assumes two things about the environment. A consumer that lowers `out_ready` may do so on any cycle. `list_start` is only acted on while `busy` is low. The bench arms each list only after the previous one has drained, and it drives exactly `list_len` words per list. It varies `out_ready` with a pseudo-random pattern during a second pass over the stimulus table. That pass exercises stalls in every mode without ever breaking the input's valid/ready contract.

// File: rtl/cbe_pkg.sv
package cbe_pkg;
  localparam int WORD_W  = 32;
  localparam int METH_W  = 13;
  localparam int SUBCH_W = 3;
  localparam int CNT_W   = 13;
  localparam int MODE_W  = 3;

  localparam int METH_LSB  = 0;
  localparam int SUBCH_LSB = METH_LSB + METH_W;
  localparam int CNT_LSB   = SUBCH_LSB + SUBCH_W;
  localparam int MODE_LSB  = CNT_LSB + CNT_W;

  typedef enum logic [MODE_W-1:0] {
    MD_STEP_OLD = 3'd0,
    MD_HOLD_OLD = 3'd1,
    MD_STEP     = 3'd2,
    MD_HOLD     = 3'd3,
    MD_IMM      = 3'd4,
    MD_ONCE     = 3'd5,
    MD_RSV_A    = 3'd6,
    MD_RSV_B    = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    STEP_EVERY = 2'd0,
    STEP_NEVER = 2'd1,
    STEP_FIRST = 2'd2
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_ARG  = 2'd2
  } state_e;

  typedef struct packed {
    logic [METH_W-1:0]  method;
    logic [SUBCH_W-1:0] subch;
    step_e              step;
  } burst_ctx_t;
endpackage

// File: rtl/cbe_hdr_decode.sv
module cbe_hdr_decode
  import cbe_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  output logic [METH_W-1:0]  method,
  output logic [SUBCH_W-1:0] subch,
  output logic [CNT_W-1:0]   count,
  output logic [WORD_W-1:0]  imm_value,
  output logic               is_burst,
  output logic               is_imm,
  output logic               is_rsv,
  output step_e              step
);
  mode_e mode;

  always_comb begin
    method    = word[METH_LSB +: METH_W];
    subch     = word[SUBCH_LSB +: SUBCH_W];
    count     = word[CNT_LSB +: CNT_W];
    mode      = mode_e'(word[MODE_LSB +: MODE_W]);
    imm_value = {{(WORD_W-CNT_W){1'b0}}, count};
    is_burst  = 1'b0;
    is_imm    = 1'b0;
    is_rsv    = 1'b0;
    step      = STEP_NEVER;
    case (mode)
      MD_STEP_OLD, MD_STEP: begin is_burst = 1'b1; step = STEP_EVERY; end
      MD_HOLD_OLD, MD_HOLD: begin is_burst = 1'b1; step = STEP_NEVER; end
      MD_ONCE:              begin is_burst = 1'b1; step = STEP_FIRST; end
      MD_IMM:               is_imm = 1'b1;
      default:              is_rsv = 1'b1;
    endcase
  end
endmodule

// File: rtl/cbe_method_step.sv
module cbe_method_step
  import cbe_pkg::*;
(
  input  step_e             step,
  input  logic [METH_W-1:0] base,
  input  logic [CNT_W-1:0]  idx,
  output logic [METH_W-1:0] method
);
  localparam logic [METH_W-1:0] ONE_M = METH_W'(1);
  localparam logic [CNT_W-1:0]  ZERO_I = '0;

  always_comb begin
    case (step)
      STEP_EVERY: method = base + METH_W'(idx);
      STEP_FIRST: method = (idx == ZERO_I) ? base : base + ONE_M;
      default:    method = base;
    endcase
  end
endmodule

// File: rtl/cbe_out_slot.sv
module cbe_out_slot
  import cbe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [METH_W-1:0]  ld_method,
  input  logic [SUBCH_W-1:0] ld_subch,
  input  logic [WORD_W-1:0]  ld_value,
  input  logic               ready,
  output logic               valid,
  output logic [METH_W-1:0]  method,
  output logic [SUBCH_W-1:0] subch,
  output logic [WORD_W-1:0]  value,
  output logic               free
);
  logic valid_d;
  logic data_en;

  always_comb begin
    free    = !valid || ready;
    data_en = load && free;
    if (data_en)    valid_d = 1'b1;
    else if (ready) valid_d = 1'b0;
    else            valid_d = valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      method <= '0;
      subch  <= '0;
      value  <= '0;
    end else if (data_en) begin
      method <= ld_method;
      subch  <= ld_subch;
      value  <= ld_value;
    end
  end
endmodule

// File: rtl/cbe_burst_expander.sv
module cbe_burst_expander
  import cbe_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               list_start,
  input  logic [LEN_W-1:0]   list_len,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [METH_W-1:0]  out_method,
  output logic [SUBCH_W-1:0] out_subch,
  output logic [WORD_W-1:0]  out_value,
  input  logic               out_ready,
  output logic               busy,
  output logic               err_unsupported,
  output logic               err_zero_once,
  output logic               err_truncated
);
  localparam logic [LEN_W-1:0] ONE_LEN  = LEN_W'(1);
  localparam logic [LEN_W-1:0] ZERO_LEN = '0;
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO_CNT = '0;

  state_e             state_q, state_d;
  logic [LEN_W-1:0]   rem_q, rem_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [CNT_W-1:0]   idx_q, idx_d;
  burst_ctx_t         ctx_q, ctx_d;
  logic               unsup_q, unsup_d;
  logic               zero_q, zero_d;
  logic               trunc_q, trunc_d;

  logic [METH_W-1:0]  hd_method;
  logic [SUBCH_W-1:0] hd_subch;
  logic [CNT_W-1:0]   hd_count;
  logic [WORD_W-1:0]  hd_imm;
  logic               hd_burst, hd_imm_mode, hd_rsv;
  step_e              hd_step;
  logic [METH_W-1:0]  arg_method;

  logic               slot_free, take, last_word, ctl_en;
  logic               wr_load;
  logic [METH_W-1:0]  wr_method;
  logic [SUBCH_W-1:0] wr_subch;
  logic [WORD_W-1:0]  wr_value;

  cbe_hdr_decode u_dec (
    .word      (in_data),
    .method    (hd_method),
    .subch     (hd_subch),
    .count     (hd_count),
    .imm_value (hd_imm),
    .is_burst  (hd_burst),
    .is_imm    (hd_imm_mode),
    .is_rsv    (hd_rsv),
    .step      (hd_step)
  );

  cbe_method_step u_step (
    .step   (ctx_q.step),
    .base   (ctx_q.method),
    .idx    (idx_q),
    .method (arg_method)
  );

  cbe_out_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_load),
    .ld_method (wr_method),
    .ld_subch  (wr_subch),
    .ld_value  (wr_value),
    .ready     (out_ready),
    .valid     (out_valid),
    .method    (out_method),
    .subch     (out_subch),
    .value     (out_value),
    .free      (slot_free)
  );

  always_comb begin
    in_ready  = (state_q != ST_IDLE) && slot_free;
    take      = in_valid && in_ready;
    last_word = (rem_q == ONE_LEN);
    busy      = (state_q != ST_IDLE);
    ctl_en    = take || (state_q == ST_IDLE && list_start);
  end

  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    left_d    = left_q;
    idx_d     = idx_q;
    ctx_d     = ctx_q;
    unsup_d   = unsup_q;
    zero_d    = zero_q;
    trunc_d   = trunc_q;
    wr_load   = 1'b0;
    wr_method = hd_method;
    wr_subch  = hd_subch;
    wr_value  = hd_imm;
    case (state_q)
      ST_IDLE: begin
        if (list_start && list_len != ZERO_LEN) begin
          state_d = ST_HDR;
          rem_d   = list_len;
        end
      end
      ST_HDR: begin
        if (take) begin
          rem_d = rem_q - ONE_LEN;
          if (last_word) state_d = ST_IDLE;
          if (hd_rsv) begin
            unsup_d = 1'b1;
          end else if (hd_imm_mode) begin
            wr_load = 1'b1;
          end else if (hd_burst && hd_count == ZERO_CNT) begin
            if (hd_step == STEP_FIRST) zero_d = 1'b1;
          end else if (last_word) begin
            trunc_d = 1'b1;
          end else begin
            state_d = ST_ARG;
            left_d  = hd_count;
            idx_d   = ZERO_CNT;
            ctx_d   = '{method: hd_method, subch: hd_subch, step: hd_step};
          end
        end
      end
      ST_ARG: begin
        if (take) begin
          wr_load   = 1'b1;
          wr_method = arg_method;
          wr_subch  = ctx_q.subch;
          wr_value  = in_data;
          idx_d     = idx_q + ONE_CNT;
          left_d    = left_q - ONE_CNT;
          rem_d     = rem_q - ONE_LEN;
          if (last_word) begin
            state_d = ST_IDLE;
            if (left_q != ONE_CNT) trunc_d = 1'b1;
          end else if (left_q == ONE_CNT) begin
            state_d = ST_HDR;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      ctx_q   <= '{method: '0, subch: '0, step: STEP_NEVER};
    end else if (ctl_en) begin
      state_q <= state_d;
      rem_q   <= rem_d;
      left_q  <= left_d;
      idx_q   <= idx_d;
      ctx_q   <= ctx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unsup_q <= 1'b0;
      zero_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else if (take) begin
      unsup_q <= unsup_d;
      zero_q  <= zero_d;
      trunc_q <= trunc_d;
    end
  end

  assign err_unsupported = unsup_q;
  assign err_zero_once   = zero_q;
  assign err_truncated   = trunc_q;
endmodule

// File: rtl/cbe_burst_expander_chk.sv
module cbe_burst_expander_chk
  import cbe_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [METH_W-1:0]  out_method,
  input logic [SUBCH_W-1:0] out_subch,
  input logic [WORD_W-1:0]  out_value,
  input logic               busy,
  input logic               err_unsupported,
  input logic               err_zero_once,
  input logic               err_truncated
);
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_STALL_HOLDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_method) &&
                                   $stable(out_subch) && $stable(out_value))); // R10
  AST_IDLE_TAKES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready); // R8
  AST_UNSUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_unsupported |=> err_unsupported); // R7
  AST_ZERO_ONCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero_once |=> err_zero_once); // R6
  AST_TRUNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_truncated |=> err_truncated); // R9
endmodule

bind cbe_burst_expander cbe_burst_expander_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_ready        (in_ready),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_method      (out_method),
  .out_subch       (out_subch),
  .out_value       (out_value),
  .busy            (busy),
  .err_unsupported (err_unsupported),
  .err_zero_once   (err_zero_once),
  .err_truncated   (err_truncated)
);

// File: tb/tb_cbe_burst_expander.sv
module tb_cbe_burst_expander;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int MAXW = 32;
  localparam int NTBL = 10;
  // headers: mode[31:29] count/imm[28:16] subch[15:13] method[12:0]
  localparam logic [31:0] TBL [NTBL] = '{
    32'h4004_2010, 32'h0003_5FFE, 32'h6003_6055, 32'h2002_80AA, 32'hA004_A100,
    32'hA001_DFFF, 32'h9ABC_E020, 32'h9FFF_0000, 32'h4000_2300, 32'h6001_4777
  };

  logic clk = 1'b0;
  logic rst_n, list_start, in_valid, in_ready, out_valid, out_ready, busy;
  logic [LEN_W-1:0] list_len;
  logic [31:0] in_data, out_value;
  logic [12:0] out_method;
  logic [2:0] out_subch;
  logic err_unsupported, err_zero_once, err_truncated;

  int errors = 0, checks = 0;
  logic [31:0] w [MAXW];
  logic [12:0] e_m [MAXW];  logic [2:0] e_s [MAXW];  logic [31:0] e_v [MAXW];
  logic [12:0] g_m [MAXW];  logic [2:0] g_s [MAXW];  logic [31:0] g_v [MAXW];
  int e_n, g_n, stall_viol;
  logic e_unsup, e_zero, e_trunc, bp_en;

  cbe_burst_expander #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .list_start(list_start), .list_len(list_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_method(out_method), .out_subch(out_subch),
    .out_value(out_value), .out_ready(out_ready), .busy(busy),
    .err_unsupported(err_unsupported), .err_zero_once(err_zero_once),
    .err_truncated(err_truncated));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && g_n < MAXW) begin
      g_m[g_n] = out_method; g_s[g_n] = out_subch; g_v[g_n] = out_value;
      g_n = g_n + 1;
    end
    if (rst_n && out_valid && !out_ready && in_ready) stall_viol = stall_viol + 1;
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model written from R1..R9
  task automatic model(input int len);
    int p;
    logic [2:0] md; logic [12:0] cnt, m; logic [2:0] sc;
    e_n = 0; p = 0;
    while (p < len) begin
      md = w[p][31:29]; cnt = w[p][28:16]; sc = w[p][15:13]; m = w[p][12:0];
      p++;
      if (md >= 3'd6) e_unsup = 1'b1;
      else if (md == 3'd4) begin
        e_m[e_n] = m; e_s[e_n] = sc; e_v[e_n] = {19'b0, cnt}; e_n++;
      end else if (cnt == 0) begin
        if (md == 3'd5) e_zero = 1'b1;
      end else begin
        for (int i = 0; i < int'(cnt); i++) begin
          if (p >= len) begin e_trunc = 1'b1; break; end
          case (md)
            3'd0, 3'd2: e_m[e_n] = m + 13'(i);
            3'd5:       e_m[e_n] = (i == 0) ? m : m + 13'd1;
            default:    e_m[e_n] = m;
          endcase
          e_s[e_n] = sc; e_v[e_n] = w[p]; e_n++; p++;
        end
      end
    end
  endtask

  task automatic run_list(input int len, input string req);
    g_n = 0;
    model(len);
    @(posedge clk); #1;
    list_start = 1'b1; list_len = LEN_W'(len);
    @(posedge clk); #1;
    list_start = 1'b0;
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1; in_data = w[k];
      forever begin @(negedge clk); if (in_ready) break; end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    forever begin @(negedge clk); if (!busy && !out_valid) break; end
    chk(g_n == e_n, {req, " write count"}, 32'(g_n), 32'(e_n));
    for (int k = 0; k < e_n && k < g_n; k++) begin
      chk(g_m[k] == e_m[k], {req, " method"}, 32'(g_m[k]), 32'(e_m[k]));
      chk(g_s[k] == e_s[k], "R1 subchannel", 32'(g_s[k]), 32'(e_s[k]));
      chk(g_v[k] == e_v[k], {req, " value"}, g_v[k], e_v[k]);
    end
    chk(err_unsupported == e_unsup, "R7 unsupported flag", 32'(err_unsupported), 32'(e_unsup));
    chk(err_zero_once == e_zero, "R6 zero-count flag", 32'(err_zero_once), 32'(e_zero));
    chk(err_truncated == e_trunc, "R9 truncation flag", 32'(err_truncated), 32'(e_trunc));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    rst_n = 1'b0; list_start = 1'b0; list_len = '0; in_valid = 1'b0; in_data = '0;
    bp_en = 1'b0; e_unsup = 0; e_zero = 0; e_trunc = 0; g_n = 0; stall_viol = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!out_valid && !in_ready && !busy, "R11 outputs idle", {out_valid, in_ready, busy}, 0);
    chk(!err_unsupported && !err_zero_once && !err_truncated, "R11 flags clear",
        {err_unsupported, err_zero_once, err_truncated}, 0);

    // table pass without, then with, backpressure: R2 R3 R4 R5 R6 R10
    for (int pass = 0; pass < 2; pass++) begin
      bp_en = (pass == 1);
      for (int t = 0; t < NTBL; t++) begin
        w[0] = TBL[t];
        n = (TBL[t][31:29] == 3'd4) ? 1 : 1 + int'(TBL[t][28:16]);
        for (int k = 1; k < n; k++) w[k] = 32'hC0DE_0000 ^ (t << 8) ^ k;
        run_list(n, "R2/R3/R4/R5");
      end
    end
    chk(stall_viol == 0, "R10 no input taken while stalled", 32'(stall_viol), 0);

    // R7: reserved modes skipped, following word decoded as header
    bp_en = 1'b0;
    w[0] = 32'hC123_0000; w[1] = 32'h8055_2044; w[2] = 32'hE000_0001;
    w[3] = 32'h4002_6100; w[4] = 32'h1111_1111; w[5] = 32'h2222_2222;
    run_list(6, "R7");

    // R6: step-once with zero count
    w[0] = 32'hA000_4010;
    run_list(1, "R6");

    // R9: list ends inside a burst
    w[0] = 32'h4005_2200; w[1] = 32'h0000_00AA; w[2] = 32'h0000_00BB;
    run_list(3, "R9");

    // R8: words after list end are not taken
    g_n = 0;
    in_valid = 1'b1; in_data = 32'h8001_0001;
    n = 0;
    for (int c = 0; c < 6; c++) begin @(negedge clk); if (in_ready) n++; end
    in_valid = 1'b0;
    chk(n == 0, "R8 in_ready low after list", 32'(n), 0);
    chk(g_n == 0 && !busy, "R8 no write after list", 32'(g_n), 0);

    // R11: reset clears sticky flags
    rst_n = 1'b0; @(negedge clk);
    chk(!err_unsupported && !err_zero_once && !err_truncated && !out_valid,
        "R11 flags cleared by reset", {err_unsupported, err_zero_once, err_truncated}, 0);
    summary();
  end
endmodule